// File: doc/BRIEF.md
# Configurable UART Receive Channel

This block receives asynchronous start-stop serial frames on a single input line and turns each frame into a parallel data word. Its configuration inputs set the word length (7, 8 or 9 bits), how the parity bit is handled, the polarity of the line, and whether the first data bit after the start bit is the least or the most significant bit. A 7-bit divisor sets the bit rate. The line passes through a two-flop synchronizer. A falling edge on the line starts a frame. The start bit is confirmed half a bit period later, and every later bit is sampled once at the middle of its period.

A frame that arrives without errors produces a one-cycle completion pulse. A frame with a framing, parity or overrun error produces a one-cycle error pulse instead, and it sets the matching sticky flag. The flags stay set until software pulses the clear input. Software pulses the read strobe once it has taken the data word. The block uses that strobe to tell whether the next frame overwrites a word that has not been read.

Top module: `uart_rx_chan`

## Requirements
- R1: After reset, `rx_data` is zero, all three error flags are low, and neither `rx_done` nor `rx_err_pulse` pulses while the line stays idle.
- R2: One bit lasts (`cfg_divisor` + 1) × 2 clock cycles. The divisor must be 2 or more, so the shortest bit is 6 cycles. Frames are received correctly at the minimum divisor, at the maximum divisor (127) and at values between.
- R3: `cfg_len` selects the number of data bits: 0 gives 7, 1 gives 8, and 2 or 3 gives 9. For 7 and 8 bits, the unused upper bits of the 9-bit `rx_data` read as zero.
- R4: When `cfg_msb_first` is 0, the first data bit after the start bit is bit 0 of the word. When it is 1, the first data bit is bit (length − 1).
- R5: When `cfg_invert` is 0, the line idles high. When it is 1, the line idles low and every sampled level is complemented before it is decoded.
- R6: `cfg_parity` selects the parity handling. 0 means the frame has no parity bit. 1 means a parity bit is received but never judged. 2 means even parity: the data bits and the parity bit together hold an even number of ones. 3 means odd parity. A mismatch in mode 2 or 3 sets `err_parity`.
- R7: Only one stop bit is checked. If it is sampled as 0 after polarity correction, `err_frame` is set. The receiver does not look for a new start bit until the corrected line has returned to 1.
- R8: Each completed frame marks its word as unread, and a `rd_strobe` pulse marks it as read. If a frame completes while the previous word is still unread, `err_overrun` is set and `rx_data` takes the new word.
- R9: A frame with no error gives exactly one `rx_done` pulse and no `rx_err_pulse`. A frame with any error gives exactly one `rx_err_pulse` and no `rx_done`. In both cases `rx_data` is updated.
- R10: The error flags are sticky. They keep their value until `clr_err` is pulsed. A flag being set in the same cycle as the clear wins over the clear.
- R11: If the line is no longer low at the middle of the start bit, the receiver treats it as a glitch. It returns to idle with no pulse, and `rx_data` and the flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operation clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len | input | 2 | Data length select: 0 = 7, 1 = 8, 2 or 3 = 9 bits |
| cfg_parity | input | 2 | Parity mode: 0 none, 1 unjudged, 2 even, 3 odd |
| cfg_invert | input | 1 | 1 inverts the line polarity |
| cfg_msb_first | input | 1 | 1 makes the first data bit the word's MSB |
| cfg_divisor | input | 7 | Baud divisor; a bit lasts (value + 1) × 2 clocks |
| rxd | input | 1 | Serial receive line |
| rd_strobe | input | 1 | Pulse: the received word has been read |
| clr_err | input | 1 | Pulse: clear the sticky error flags |
| rx_data | output | 9 | Last received word, zero-extended |
| rx_done | output | 1 | One-cycle pulse for an error-free frame |
| rx_err_pulse | output | 1 | One-cycle pulse for a frame with any error |
| err_frame | output | 1 | Sticky framing error flag |
| err_parity | output | 1 | Sticky parity error flag |
| err_overrun | output | 1 | Sticky overrun error flag |

## Verification
The bench sends frames that combine every length, every parity mode and both polarities and bit orders, at divisors from the minimum up to 127. A receiver that mis-times its sampling point loses bits at the 6-cycle bit period. A receiver that mixes up bit order or polarity returns a word that is mirrored or complemented. Corrupted parity bits are sent in the even and odd modes and in the unjudged mode. A design that judges parity in the unjudged mode raises a false error, and one that ignores the mode bits misses the real errors. The bench also checks these behaviours:
- A low stop bit must raise the framing flag without causing a phantom second frame.
- Two frames in a row with no read must raise the overrun flag and the error pulse rather than a completion pulse.
- A short low glitch must leave the outputs unchanged.
- The flags must hold until they are cleared.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_HOLD
  } rx_state_e;

  typedef enum logic [1:0] {
    PAR_NONE  = 2'd0,
    PAR_BLIND = 2'd1,
    PAR_EVEN  = 2'd2,
    PAR_ODD   = 2'd3
  } par_mode_e;

endpackage

// File: rtl/uart_rx_baud.sv
module uart_rx_baud #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             half,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;

  always_comb begin
    limit = half ? {1'b0, div} : {div, 1'b1};
    tick  = run && (cnt_q == limit);
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_DIV_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (div >= DIV_W'(2))) else $error("divisor below 2"); // R2

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= {div, 1'b1})) else $error("bit counter overran"); // R2

endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line,
  input  logic [1:0]        cfg_len,
  input  logic [1:0]        cfg_parity,
  input  logic              cfg_msb_first,
  input  logic              tick,
  output logic              run,
  output logic              half,
  output logic              fin,
  output logic              fe,
  output logic              pe,
  output logic [DATA_W-1:0] word
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  rx_state_e        st_q, st_d;
  logic [CNT_W-1:0] bit_q, bit_d, nbits, pos;
  logic [DATA_W-1:0] word_q, word_d;
  logic             acc_q, acc_d;
  par_mode_e        pmode;

  always_comb begin
    pmode = par_mode_e'(cfg_parity);
    case (cfg_len)
      2'd0:    nbits = CNT_W'(DATA_W - 2);
      2'd1:    nbits = CNT_W'(DATA_W - 1);
      default: nbits = CNT_W'(DATA_W);
    endcase
    pos  = cfg_msb_first ? (nbits - 1'b1 - bit_q) : bit_q;
    run  = (st_q == ST_START) || (st_q == ST_DATA) ||
           (st_q == ST_PAR)   || (st_q == ST_STOP);
    half = (st_q == ST_START);
  end

  always_comb begin
    st_d   = st_q;
    bit_d  = bit_q;
    word_d = word_q;
    acc_d  = acc_q;
    fin    = 1'b0;
    fe     = 1'b0;
    pe     = 1'b0;
    case (st_q)
      ST_IDLE: if (!line) begin
        st_d   = ST_START;
        bit_d  = '0;
        word_d = '0;
        acc_d  = 1'b0;
      end
      ST_START: if (tick) st_d = line ? ST_IDLE : ST_DATA;
      ST_DATA: if (tick) begin
        word_d[pos] = line;
        acc_d       = acc_q ^ line;
        bit_d       = bit_q + 1'b1;
        if (bit_q == nbits - 1'b1)
          st_d = (pmode == PAR_NONE) ? ST_STOP : ST_PAR;
      end
      ST_PAR: if (tick) begin
        acc_d = acc_q ^ line;
        st_d  = ST_STOP;
      end
      ST_STOP: if (tick) begin
        fin  = 1'b1;
        fe   = !line;
        pe   = ((pmode == PAR_EVEN) && acc_q) || ((pmode == PAR_ODD) && !acc_q);
        st_d = ST_HOLD;
      end
      ST_HOLD: if (line) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      bit_q  <= '0;
      word_q <= '0;
      acc_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      bit_q  <= bit_d;
      word_q <= word_d;
      acc_q  <= acc_d;
    end
  end

  assign word = word_q;

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && cfg_len == 2'd0) |-> (word_q[DATA_W-1 -: 2] == 2'b00)) else $error("upper bits set"); // R3

  AST_HOLD_UNTIL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD && !line) |=> (st_q == ST_HOLD)) else $error("left hold on low line"); // R7

  AST_GLITCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_START && tick && line) |=> (st_q == ST_IDLE)) else $error("glitch accepted"); // R11

endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fin,
  input  logic              fe,
  input  logic              pe,
  input  logic [DATA_W-1:0] word,
  input  logic              rd_strobe,
  input  logic              clr_err,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_done,
  output logic              rx_err_pulse,
  output logic              err_frame,
  output logic              err_parity,
  output logic              err_overrun
);
  logic [DATA_W-1:0] data_q, data_d;
  logic done_q, done_d, errp_q, errp_d, unread_q, unread_d;
  logic fe_q, fe_d, pe_q, pe_d, ov_q, ov_d, ov_now, any_err;

  always_comb begin
    ov_now   = fin && unread_q && !rd_strobe;
    any_err  = fe || pe || ov_now;
    done_d   = fin && !any_err;
    errp_d   = fin && any_err;
    data_d   = fin ? word : data_q;
    unread_d = fin ? 1'b1 : (rd_strobe ? 1'b0 : unread_q);
    fe_d     = (fin && fe) || (fe_q && !clr_err);
    pe_d     = (fin && pe) || (pe_q && !clr_err);
    ov_d     = ov_now || (ov_q && !clr_err);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      done_q   <= 1'b0;
      errp_q   <= 1'b0;
      unread_q <= 1'b0;
      fe_q     <= 1'b0;
      pe_q     <= 1'b0;
      ov_q     <= 1'b0;
    end else begin
      data_q   <= data_d;
      done_q   <= done_d;
      errp_q   <= errp_d;
      unread_q <= unread_d;
      fe_q     <= fe_d;
      pe_q     <= pe_d;
      ov_q     <= ov_d;
    end
  end

  assign rx_data      = data_q;
  assign rx_done      = done_q;
  assign rx_err_pulse = errp_q;
  assign err_frame    = fe_q;
  assign err_parity   = pe_q;
  assign err_overrun  = ov_q;

  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && errp_q)) else $error("done and error together"); // R9

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q) else $error("done wider than one cycle"); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_q && !clr_err) |=> fe_q) else $error("frame flag dropped"); // R10

  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && unread_q && !rd_strobe) |=> ov_q) else $error("overrun missed"); // R8

endmodule

// File: rtl/uart_rx_chan.sv
module uart_rx_chan #(
  parameter int DATA_W = 9,
  parameter int DIV_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_len,
  input  logic [1:0]        cfg_parity,
  input  logic              cfg_invert,
  input  logic              cfg_msb_first,
  input  logic [DIV_W-1:0]  cfg_divisor,
  input  logic              rxd,
  input  logic              rd_strobe,
  input  logic              clr_err,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_done,
  output logic              rx_err_pulse,
  output logic              err_frame,
  output logic              err_parity,
  output logic              err_overrun
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic [1:0] rxd_sync_q;
  logic       line, tick, run, half, fin, fe, pe;
  logic [DATA_W-1:0] word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rxd_sync_q <= 2'b11;
    else            rxd_sync_q <= {rxd_sync_q[0], rxd};
  end
  assign line = rxd_sync_q[1] ^ cfg_invert;

  uart_rx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_int_n), .run(run), .half(half),
    .div(cfg_divisor), .tick(tick)
  );

  uart_rx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_int_n), .line(line), .cfg_len(cfg_len),
    .cfg_parity(cfg_parity), .cfg_msb_first(cfg_msb_first), .tick(tick),
    .run(run), .half(half), .fin(fin), .fe(fe), .pe(pe), .word(word)
  );

  uart_rx_flags #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst_n(rst_int_n), .fin(fin), .fe(fe), .pe(pe), .word(word),
    .rd_strobe(rd_strobe), .clr_err(clr_err), .rx_data(rx_data),
    .rx_done(rx_done), .rx_err_pulse(rx_err_pulse), .err_frame(err_frame),
    .err_parity(err_parity), .err_overrun(err_overrun)
  );

endmodule

// File: tb/uart_rx_chan_bench.sv
module uart_rx_chan_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_len = 2'd1;
  logic [1:0] cfg_parity = 2'd0;
  logic       cfg_invert = 1'b0;
  logic       cfg_msb_first = 1'b0;
  logic [6:0] cfg_divisor = 7'd4;
  logic       rxd = 1'b1;
  logic       rd_strobe = 1'b0;
  logic       clr_err = 1'b0;
  logic [8:0] rx_data;
  logic       rx_done, rx_err_pulse, err_frame, err_parity, err_overrun;

  int n_chk = 0, n_bad = 0, n_done = 0, n_err = 0, cyc = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  uart_rx_chan u_uart_rx_chan (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_parity(cfg_parity),
    .cfg_invert(cfg_invert), .cfg_msb_first(cfg_msb_first),
    .cfg_divisor(cfg_divisor), .rxd(rxd), .rd_strobe(rd_strobe),
    .clr_err(clr_err), .rx_data(rx_data), .rx_done(rx_done),
    .rx_err_pulse(rx_err_pulse), .err_frame(err_frame),
    .err_parity(err_parity), .err_overrun(err_overrun)
  );

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (rx_done)      n_done++;
      if (rx_err_pulse) n_err++;
    end
    if (cyc > 150000 && !finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  typedef struct packed {
    logic [1:0] len;
    logic [1:0] par;
    logic       inv;
    logic       msb;
    logic [6:0] div;
    logic [8:0] val;
    logic       badp;
    logic       bads;
    logic [8:0] exp_d;
    logic       exp_fe;
    logic       exp_pe;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 2'd0, 1'b0, 1'b0, 7'd2,   9'h0A5, 1'b0, 1'b0, 9'h0A5, 1'b0, 1'b0},
    '{2'd0, 2'd2, 1'b0, 1'b0, 7'd4,   9'h0D3, 1'b0, 1'b0, 9'h053, 1'b0, 1'b0},
    '{2'd2, 2'd3, 1'b0, 1'b1, 7'd3,   9'h1A6, 1'b0, 1'b0, 9'h1A6, 1'b0, 1'b0},
    '{2'd1, 2'd2, 1'b1, 1'b1, 7'd5,   9'h03C, 1'b0, 1'b0, 9'h03C, 1'b0, 1'b0},
    '{2'd1, 2'd2, 1'b0, 1'b0, 7'd2,   9'h081, 1'b1, 1'b0, 9'h081, 1'b0, 1'b1},
    '{2'd1, 2'd3, 1'b1, 1'b0, 7'd6,   9'h07E, 1'b1, 1'b0, 9'h07E, 1'b0, 1'b1},
    '{2'd1, 2'd1, 1'b0, 1'b0, 7'd4,   9'h055, 1'b1, 1'b0, 9'h055, 1'b0, 1'b0},
    '{2'd2, 2'd0, 1'b0, 1'b0, 7'd2,   9'h155, 1'b0, 1'b1, 9'h155, 1'b1, 1'b0},
    '{2'd0, 2'd0, 1'b1, 1'b1, 7'd127, 9'h041, 1'b0, 1'b0, 9'h041, 1'b0, 1'b0},
    '{2'd1, 2'd0, 1'b0, 1'b1, 7'd2,   9'h001, 1'b0, 1'b0, 9'h001, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic lvl, input int p);
    rxd = lvl ^ cfg_invert;
    wait_clk(p);
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    wait_clk(1);
    sig = 1'b0;
  endtask

  task automatic setup(input logic [1:0] len, input logic [1:0] par, input logic inv,
                       input logic msb, input logic [6:0] div);
    cfg_len = len; cfg_parity = par; cfg_invert = inv;
    cfg_msb_first = msb; cfg_divisor = div;
    rxd = ~inv;
    wait_clk(2 * (int'(div) + 1) * 3);
  endtask

  task automatic send(input logic [8:0] val, input logic badp, input logic bads);
    int p = (int'(cfg_divisor) + 1) * 2;
    int nb = (cfg_len == 2'd0) ? 7 : (cfg_len == 2'd1) ? 8 : 9;
    logic ones = 1'b0;
    logic pbit;
    drive(1'b0, p);
    for (int i = 0; i < nb; i++) begin
      int idx = cfg_msb_first ? (nb - 1 - i) : i;
      ones ^= val[idx];
      drive(val[idx], p);
    end
    if (cfg_parity != 2'd0) begin
      pbit = (cfg_parity == 2'd3) ? ~ones : ((cfg_parity == 2'd2) ? ones : 1'b0);
      drive(pbit ^ badp, p);
    end
    drive(~bads, p);
    drive(1'b1, 2 * p);
  endtask

  initial begin
    int d0, e0;
    logic [8:0] keep;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(20);
    // R1: reset state
    check("R1 rx_data", rx_data, 0);
    check("R1 flags", {err_frame, err_parity, err_overrun}, 0);
    check("R1 pulses", n_done + n_err, 0);

    // Vector table walk
    for (int v = 0; v < NV; v++) begin
      string tag;
      setup(VECS[v].len, VECS[v].par, VECS[v].inv, VECS[v].msb, VECS[v].div);
      d0 = n_done; e0 = n_err;
      send(VECS[v].val, VECS[v].badp, VECS[v].bads);
      tag = VECS[v].inv ? "R5 data" : VECS[v].msb ? "R4 data" :
            (VECS[v].len != 2'd1) ? "R3 data" : "R2 data";
      check(tag, rx_data, VECS[v].exp_d);
      check("R6 parity flag", err_parity, VECS[v].exp_pe);
      check("R7 frame flag", err_frame, VECS[v].exp_fe);
      check("R9 done count", n_done - d0, (VECS[v].exp_fe | VECS[v].exp_pe) ? 0 : 1);
      check("R9 err count", n_err - e0, (VECS[v].exp_fe | VECS[v].exp_pe) ? 1 : 0);
      pulse(rd_strobe);
      pulse(clr_err);
    end

    // R8: overrun on two frames without a read
    setup(2'd1, 2'd0, 1'b0, 1'b0, 7'd3);
    d0 = n_done; e0 = n_err;
    send(9'h012, 1'b0, 1'b0);
    send(9'h034, 1'b0, 1'b0);
    check("R8 overrun flag", err_overrun, 1);
    check("R8 new data kept", rx_data, 9'h034);
    check("R9 overrun done count", n_done - d0, 1);
    check("R9 overrun err count", n_err - e0, 1);

    // R10: flag sticks until cleared
    wait_clk(60);
    check("R10 sticky", err_overrun, 1);
    pulse(clr_err);
    check("R10 cleared", err_overrun, 0);
    pulse(rd_strobe);
    send(9'h0F0, 1'b0, 1'b0);
    check("R8 read avoids overrun", err_overrun, 0);
    pulse(rd_strobe);

    // R11: short start glitch ignored
    setup(2'd1, 2'd0, 1'b0, 1'b0, 7'd4);
    keep = rx_data;
    d0 = n_done; e0 = n_err;
    drive(1'b0, 2);
    drive(1'b1, 40);
    check("R11 no pulse", (n_done - d0) + (n_err - e0), 0);
    check("R11 data unchanged", rx_data, keep);
    check("R11 flags unchanged", {err_frame, err_parity, err_overrun}, 0);
    send(9'h0C3, 1'b0, 1'b0);
    check("R11 frame after glitch", rx_data, 9'h0C3);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule